// File: doc/BRIEF.md
# Bridging Fault Injector

This block sits between a pair of fault-free logic lines, A and B, and the logic that reads them. A fault-grading testbench uses it to emulate a short between the two lines. Each line is a `WIDTH`-bit vector, and every bit position is an independent bridged pair. A 3-bit mode input picks the behaviour that both faulty lines take. The choices are pass-through, wired-AND, wired-OR, A-dominant, B-dominant, and a feedback-OR short that can hold state.

Each line also drives `FANOUT` branch copies. A short on one branch forces the stem and all of its sibling branches to the same faulty value, so every branch equals its line's faulty output. The mode is captured on the clock edge, which keeps a mode change from glitching within a cycle. The data path itself is combinational.

Top module: `bridge_fault_inj`

## Requirements
- R1: With registered mode code 000, 110 or 111, a_o equals a_i and b_o equals b_i in the same cycle, with no added latency.
- R2: With mode code 001 (wired-AND), a_o and b_o both equal a_i AND b_i, bit by bit. The per-bit pairs (a,b) = 00, 01, 10, 11 give 00, 00, 00, 11.
- R3: With mode code 010 (wired-OR), a_o and b_o both equal a_i OR b_i, bit by bit. The per-bit pairs 00, 01, 10, 11 give 00, 11, 11, 11.
- R4: With mode code 011, both outputs equal a_i. With mode code 100, both outputs equal b_i.
- R5: With mode code 101 (feedback-OR), both outputs equal a_i OR b_i OR the held bits. The held bits are a WIDTH-bit register that captures a_o at every rising clock edge, whatever the mode. While this mode stays selected, a bit that has gone to 1 therefore stays at 1.
- R6: A new mode_i value takes effect only after the next rising clock edge. Until that edge, the outputs follow the previously registered mode.
- R7: Every branch output equals the faulty value of its line. Branch k of a line sits at bits [k*WIDTH +: WIDTH] of a_fan_o or b_fan_o.
- R8: Reset is synchronous and active-low. A rising edge with rst_n low sets the registered mode to 000 and clears the held bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Requested fault mode, registered on the clock edge |
| a_i | input | WIDTH | Fault-free value of line A |
| b_i | input | WIDTH | Fault-free value of line B |
| a_o | output | WIDTH | Faulty value of line A (stem) |
| b_o | output | WIDTH | Faulty value of line B (stem) |
| a_fan_o | output | FANOUT*WIDTH | Branch copies of the faulty line A |
| b_fan_o | output | FANOUT*WIDTH | Branch copies of the faulty line B |

## Verification
Data outputs respond to a_i and b_i in the same cycle. The bench drives those inputs on the falling edge and compares one nanosecond later, before any register can move. A change on mode_i is due one rising edge later, so the bench compares once before that edge, expecting the old behaviour, and once after it, expecting the new. The held bits of the feedback mode are the only state that carries across cycles. The bench keeps its own copy of them, updated at each rising edge from its own expected a_o, so every feedback result is predicted from the previous cycle's expected output.

// File: rtl/bfi_pkg.sv
// Shared mode codes for the bridging fault injector.
package bfi_pkg;
    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] BR_NONE = 3'b000;
    localparam logic [MODE_W-1:0] BR_AND  = 3'b001;
    localparam logic [MODE_W-1:0] BR_OR   = 3'b010;
    localparam logic [MODE_W-1:0] BR_ADOM = 3'b011;
    localparam logic [MODE_W-1:0] BR_BDOM = 3'b100;
    localparam logic [MODE_W-1:0] BR_FBOR = 3'b101;
endpackage

// File: rtl/bfi_mode_reg.sv
// Mode register: captures the requested fault mode on each clock edge.
// Assumes a synchronous active-low reset that returns the mode to pass-through.
module bfi_mode_reg
    import bfi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_d,
    output logic [MODE_W-1:0] mode_q
);
    // Latch the mode once per cycle so it cannot change within a cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= BR_NONE;
        else        mode_q <= mode_d;
    end
endmodule

// File: rtl/bfi_fb_reg.sv
// Held-bit register: stores the previous faulty value of line A for the
// feedback short. Assumes a synchronous active-low reset to a known zero.
module bfi_fb_reg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the line value every cycle; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/bfi_resolve.sv
// Combinational resolver: computes the faulty value of both shorted lines
// from the fault-free pair, the registered mode and the held bits.
// Assumes every bit position is an independent bridged pair.
module bfi_resolve
    import bfi_pkg::*;
#(
    parameter int W = 2
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic [W-1:0]      held,
    output logic [W-1:0]      a_f,
    output logic [W-1:0]      b_f
);
    // Select the wired behaviour; unlisted codes act as no fault.
    always_comb begin
        a_f = a;
        b_f = b;
        case (mode)
            BR_AND:  begin a_f = a & b;        b_f = a & b;        end
            BR_OR:   begin a_f = a | b;        b_f = a | b;        end
            BR_ADOM: begin a_f = a;            b_f = a;            end
            BR_BDOM: begin a_f = b;            b_f = b;            end
            BR_FBOR: begin a_f = a | b | held; b_f = a | b | held; end
            default: begin a_f = a;            b_f = b;            end
        endcase
    end
endmodule

// File: rtl/bridge_fault_inj.sv
// Bridging fault injector top: registered mode, combinational resolution of
// the shorted pair, a held-bit register for the feedback short, and fanout
// branches that all carry their line's faulty value.
// Assumes inputs settle within the cycle; the data path adds no register.
module bridge_fault_inj
    import bfi_pkg::*;
#(
    parameter int WIDTH  = 2,
    parameter int FANOUT = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [MODE_W-1:0]       mode_i,
    input  logic [WIDTH-1:0]        a_i,
    input  logic [WIDTH-1:0]        b_i,
    output logic [WIDTH-1:0]        a_o,
    output logic [WIDTH-1:0]        b_o,
    output logic [FANOUT*WIDTH-1:0] a_fan_o,
    output logic [FANOUT*WIDTH-1:0] b_fan_o
);
    logic [MODE_W-1:0] mode_q;
    logic [WIDTH-1:0]  fb_q;
    logic [WIDTH-1:0]  a_f;
    logic [WIDTH-1:0]  b_f;

    bfi_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_d (mode_i),
        .mode_q (mode_q)
    );

    bfi_fb_reg #(.W(WIDTH)) u_fb (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (a_f),
        .q     (fb_q)
    );

    bfi_resolve #(.W(WIDTH)) u_res (
        .mode (mode_q),
        .a    (a_i),
        .b    (b_i),
        .held (fb_q),
        .a_f  (a_f),
        .b_f  (b_f)
    );

    // Stem outputs carry the resolved faulty values.
    assign a_o = a_f;
    assign b_o = b_f;

    // Each branch mirrors its stem, as a shorted branch drags the whole net.
    for (genvar k = 0; k < FANOUT; k++) begin : g_branch
        assign a_fan_o[k*WIDTH +: WIDTH] = a_f;
        assign b_fan_o[k*WIDTH +: WIDTH] = b_f;
    end
endmodule

// File: rtl/bfi_checker.sv
// Property checker for the bridging fault injector, bound to the top.
module bfi_checker
    import bfi_pkg::*;
#(
    parameter int W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_i,
    input logic [MODE_W-1:0] mode_q,
    input logic [W-1:0]      a_i,
    input logic [W-1:0]      b_i,
    input logic [W-1:0]      a_o,
    input logic [W-1:0]      b_o,
    input logic [W-1:0]      fb_q
);
    a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == BR_NONE) |-> (a_o == a_i && b_o == b_i));

    a_r2_wired_and: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == BR_AND) |-> (a_o == (a_i & b_i) && b_o == a_o));

    a_r3_wired_or: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == BR_OR) |-> (a_o == (a_i | b_i) && b_o == a_o));

    a_r4_a_dominant: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == BR_ADOM) |-> (a_o == a_i && b_o == a_i));

    a_r4_b_dominant: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == BR_BDOM) |-> (a_o == b_i && b_o == b_i));

    a_r5_feedback_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == BR_FBOR && $past(rst_n)) |-> ((a_o & $past(a_o)) == $past(a_o)));

    a_r6_mode_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (mode_q == $past(mode_i)));

    a_r8_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_q == BR_NONE && fb_q == '0));
endmodule

bind bridge_fault_inj bfi_checker #(.W(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .mode_q (mode_q),
    .a_i    (a_i),
    .b_i    (b_i),
    .a_o    (a_o),
    .b_o    (b_o),
    .fb_q   (fb_q)
);

// File: tb/bridge_fault_inj_tb_top.sv
// Self-checking bench: sweeps every mode against every input pair.
module bridge_fault_inj_tb_top;
    localparam int W = 2;
    localparam int F = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2:0]     mode_i = 3'b011;
    logic [W-1:0]   a_i = '1;
    logic [W-1:0]   b_i = '0;
    logic [W-1:0]   a_o, b_o;
    logic [F*W-1:0] a_fan_o, b_fan_o;

    int errors = 0;
    int checks = 0;

    // Bench-side model state: mode and held bits.
    logic [2:0]   m_mode = 3'b000;
    logic [W-1:0] m_held = '0;

    always #4 clk = ~clk;

    bridge_fault_inj #(.WIDTH(W), .FANOUT(F)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .a_o     (a_o),
        .b_o     (b_o),
        .a_fan_o (a_fan_o),
        .b_fan_o (b_fan_o)
    );

    function automatic logic [2*W-1:0] expect_pair(input logic [2:0] m,
            input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] h);
        case (m)
            3'd1:    return {a & b, a & b};
            3'd2:    return {a | b, a | b};
            3'd3:    return {a, a};
            3'd4:    return {b, b};
            3'd5:    return {a | b | h, a | b | h};
            default: return {a, b};
        endcase
    endfunction

    // Advance the bench model on each rising edge.
    always @(posedge clk) begin
        logic [2*W-1:0] e;
        e = expect_pair(m_mode, a_i, b_i, m_held);
        if (!rst_n) begin
            m_mode <= 3'b000;
            m_held <= '0;
        end else begin
            m_mode <= mode_i;
            m_held <= e[2*W-1:W];
        end
    end

    task automatic cmp(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b mode=%0d a=%b b=%b",
                     req, act, exp, m_mode, a_i, b_i);
        end
    endtask

    // Compare stems and every branch against the model.
    task automatic check_model(input string req);
        logic [2*W-1:0] e;
        e = expect_pair(m_mode, a_i, b_i, m_held);
        cmp(req, a_o, e[2*W-1:W]);
        cmp(req, b_o, e[W-1:0]);
        for (int k = 0; k < F; k++) begin
            cmp("R7", a_fan_o[k*W +: W], e[2*W-1:W]);
            cmp("R7", b_fan_o[k*W +: W], e[W-1:0]);
        end
    endtask

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3, 3'd4: return "R4";
            3'd5: return "R5";
            default: return "R1";
        endcase
    endfunction

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        a_i = a;
        b_i = b;
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        // R8: reset state -> pass-through even though mode_i asks for A-dominant.
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mode_i = 3'b000;
        #1;
        cmp("R8", a_o, a_i);
        cmp("R8", b_o, b_i);

        // Exhaustive sweep: every mode code, every input pair (R1..R5, R7).
        for (int m = 0; m < 8; m++) begin
            @(negedge clk);
            mode_i = 3'(m);
            @(posedge clk);
            for (int v = 0; v < (1 << (2 * W)); v++) begin
                drive(v[2*W-1:W], v[W-1:0]);
                check_model(req_of(3'(m)));
            end
        end

        // R6: mode change waits for the edge.
        @(negedge clk);
        mode_i = 3'b001;
        @(posedge clk);
        drive(2'b11, 2'b01);
        cmp("R6", a_o, 2'b01);
        @(negedge clk);
        mode_i = 3'b010;
        #1;
        cmp("R6", a_o, 2'b01);
        @(posedge clk);
        #1;
        cmp("R6", a_o, 2'b11);

        // R8 + R5: reset clears held bits, then a one-cycle pulse is held.
        @(negedge clk);
        rst_n = 1'b0;
        mode_i = 3'b101;
        a_i = '0;
        b_i = '0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        cmp("R8", a_o, 2'b00);
        @(posedge clk);
        drive(2'b01, 2'b00);
        cmp("R5", a_o, 2'b01);
        drive(2'b00, 2'b00);
        cmp("R5", a_o, 2'b01);
        cmp("R5", b_o, 2'b01);
        drive(2'b00, 2'b10);
        cmp("R5", a_o, 2'b11);
        drive(2'b00, 2'b00);
        cmp("R5", b_o, 2'b11);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule